// File: doc/BRIEF.md
# Two-ROM Microcoded Instruction Sequencer

This block is the control unit of a multicycle 8-bit processor. It steps a 7-bit state register through a computed state ROM and keeps a second ROM that decodes opcodes. In the single base state the sequencer takes the opcode byte from the memory data bus. The opcode ROM names the first execution state for that opcode and also supplies a set of control signals for it. Each state word carries a select bit, a 2-bit sequencing mode and a next-state field. The select bit decides whether the control word driven out comes from the state itself or from the opcode ROM. The sequencing mode decides where the sequencer goes next.

Conditional branches are handled in a dedicated test state. That state compares one processor flag with a polarity taken from the latched opcode. If the branch is taken, the sequencer runs two more states. If it is not taken, it goes straight back to the base state. Undefined opcodes run a one-cycle no-op. The datapath, decimal arithmetic and interrupts are handled elsewhere.

Top module: `useq_top`

## Requirements
- R1: While `rst_ni` is low, `state_o` is 0 and the held opcode is 0. In state 0, `ctrl_o` is the state's own word, 16'h00FF.
- R2: In state 0 the byte `op` on `mem_data_i` is captured as the opcode. The next state is the entry for `op`:
  - 2 for the branch opcodes 0x10..0x17;
  - 1 for the undefined opcodes 151..255;
  - otherwise 5 + 4*(op mod 28) + ((op div 28) mod 4).
- R3: The held opcode changes only at an edge where the state is 0. `mem_data_i` has no effect in any other state.
- R4: The select bit is set in states 3 and 4, and in states s >= 5 where (s-5) is odd. When it is set, `ctrl_o` = {op, op ^ 8'h5A}, with op the held opcode. Otherwise `ctrl_o` = {s, 2'b01, ~s}, with s the 7-bit state.
- R5: Branches are decided in state 2:
  - Opcode bits [1:0] select the flag: `flags_i` bit 0 = C, bit 1 = Z, bit 2 = V, bit 3 = N.
  - Opcode bit 2 is the polarity. The branch is taken when the selected flag equals it.
  - A taken branch goes 2 -> 3 -> 4 -> 0. A branch that is not taken goes 2 -> 0.
- R6: A state s >= 5 returns to state 0 when (s-5) mod 4 = 3, or when s = 117. Otherwise it advances to s+1.
- R7: An undefined opcode spends exactly one cycle in state 1 and then returns to state 0.
- R8: `state_o` never exceeds 117, the last of the 118 states.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mem_data_i | input | 8 | Memory data byte; taken as the opcode in state 0 |
| flags_i | input | 4 | Processor flags {N, V, Z, C} |
| ctrl_o | output | 16 | Control word for the datapath |
| state_o | output | 7 | Current sequencer state |

## Verification
The assertions check on every cycle that:
- the held opcode stays stable outside the base state;
- the no-op state always returns to base;
- the branch test state only ever exits to base or to the taken path;
- dispatch never lands on base;
- the state stays in range.

Only the bench's scenarios can show that the right values are chosen. It compares the control word and the state on every clock against a behavioural model. The scenarios sweep every opcode, all eight branch opcodes under all sixteen flag combinations, and undefined opcodes with garbage bytes on the bus while the instruction is still running.

// File: rtl/useq_pkg.sv
package useq_pkg;
  parameter int unsigned STATE_W    = 7;
  parameter int unsigned DATA_W     = 8;
  parameter int unsigned FLAG_W     = 4;
  parameter int unsigned NUM_STATES = 118;
  parameter int unsigned NUM_VALID  = 151;
  parameter int unsigned CHAIN_LEN  = 4;
  parameter int unsigned NUM_CHAINS = 28;

  localparam int unsigned CTRL_W  = 2 * DATA_W;
  localparam int unsigned FSEL_W  = $clog2(FLAG_W);
  localparam logic [DATA_W-1:0] OP_MIX = 8'h5A;

  localparam logic [STATE_W-1:0] ST_BASE   = 7'd0;
  localparam logic [STATE_W-1:0] ST_NOP    = 7'd1;
  localparam logic [STATE_W-1:0] ST_BRTEST = 7'd2;
  localparam logic [STATE_W-1:0] ST_BRTAKE = 7'd3;
  localparam logic [STATE_W-1:0] ST_BRDONE = 7'd4;
  localparam int unsigned        ST_CHAIN  = 5;
  localparam logic [DATA_W-1:4]  BR_GROUP  = 4'h1;

  typedef enum logic [1:0] {
    SEQ_NEXT     = 2'd0,
    SEQ_BASE     = 2'd1,
    SEQ_DISPATCH = 2'd2,
    SEQ_BRANCH   = 2'd3
  } seq_mode_e;

  typedef struct packed {
    logic                sel_op;
    seq_mode_e           mode;
    logic [STATE_W-1:0]  nxt;
    logic [CTRL_W-1:0]   ctrl;
  } state_word_t;

  function automatic logic [CTRL_W-1:0] own_ctrl(input int unsigned s);
    logic [STATE_W-1:0] v;
    v = STATE_W'(s);
    return {v, 2'b01, ~v};
  endfunction

  function automatic state_word_t build_word(input int unsigned s);
    state_word_t w;
    int unsigned k;
    w.sel_op = 1'b0;
    w.mode   = SEQ_BASE;
    w.nxt    = ST_BASE;
    w.ctrl   = own_ctrl(s);
    k        = 0;
    if (s == 0) begin
      w.mode = SEQ_DISPATCH;
    end else if (s == 2) begin
      w.mode = SEQ_BRANCH;
      w.nxt  = ST_BRTAKE;
    end else if (s == 3) begin
      w.sel_op = 1'b1;
      w.mode   = SEQ_NEXT;
      w.nxt    = ST_BRDONE;
    end else if (s == 4) begin
      w.sel_op = 1'b1;
    end else if (s >= ST_CHAIN && s < NUM_STATES) begin
      k        = s - ST_CHAIN;
      w.sel_op = (k % 2) == 1;
      if ((k % CHAIN_LEN) != CHAIN_LEN - 1 && s != NUM_STATES - 1) begin
        w.mode = SEQ_NEXT;
        w.nxt  = STATE_W'(s + 1);
      end
    end
    return w;
  endfunction
endpackage

// File: rtl/useq_state_rom.sv
module useq_state_rom
  import useq_pkg::*;
(
  input  logic [STATE_W-1:0] addr_i,
  output state_word_t        word_o
);
  state_word_t rom [NUM_STATES];

  for (genvar g = 0; g < NUM_STATES; g++) begin : g_word
    assign rom[g] = build_word(g);
  end

  assign word_o = (int'(addr_i) < NUM_STATES) ? rom[addr_i] : build_word(NUM_STATES);
endmodule

// File: rtl/useq_opcode_rom.sv
module useq_opcode_rom
  import useq_pkg::*;
(
  input  logic [DATA_W-1:0]  opcode_i,
  output logic [STATE_W-1:0] entry_o,
  output logic [CTRL_W-1:0]  ctrl_o
);
  int unsigned op_int;
  int unsigned chain_base;
  int unsigned chain_off;

  always_comb begin
    op_int     = int'(opcode_i);
    chain_base = ST_CHAIN + CHAIN_LEN * (op_int % NUM_CHAINS);
    chain_off  = (op_int / NUM_CHAINS) % CHAIN_LEN;
    if (opcode_i[DATA_W-1:4] == BR_GROUP && !opcode_i[3])
      entry_o = ST_BRTEST;
    else if (op_int >= NUM_VALID)
      entry_o = ST_NOP;
    else
      entry_o = STATE_W'(chain_base + chain_off);
  end

  assign ctrl_o = {opcode_i, opcode_i ^ OP_MIX};
endmodule

// File: rtl/useq_branch_eval.sv
module useq_branch_eval
  import useq_pkg::*;
(
  input  logic [FLAG_W-1:0] flags_i,
  input  logic [FSEL_W-1:0] flag_sel_i,
  input  logic              polarity_i,
  output logic              taken_o
);
  assign taken_o = (flags_i[flag_sel_i] == polarity_i);
endmodule

// File: rtl/useq_top.sv
module useq_top
  import useq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [7:0]        mem_data_i,
  input  logic [3:0]        flags_i,
  output logic [15:0]       ctrl_o,
  output logic [6:0]        state_o
);
  logic [STATE_W-1:0] state_q, state_d;
  logic [DATA_W-1:0]  opcode_q;
  logic [DATA_W-1:0]  rom_addr;
  logic [STATE_W-1:0] op_entry;
  logic [CTRL_W-1:0]  op_ctrl;
  logic               br_taken;
  logic               in_base;
  state_word_t        word;

  assign in_base  = (state_q == ST_BASE);
  // base cycle decodes the live byte; later cycles decode the held opcode
  assign rom_addr = in_base ? mem_data_i : opcode_q;

  useq_state_rom u_state_rom (
    .addr_i (state_q),
    .word_o (word)
  );

  useq_opcode_rom u_opcode_rom (
    .opcode_i (rom_addr),
    .entry_o  (op_entry),
    .ctrl_o   (op_ctrl)
  );

  useq_branch_eval u_branch_eval (
    .flags_i    (flags_i),
    .flag_sel_i (opcode_q[FSEL_W-1:0]),
    .polarity_i (opcode_q[2]),
    .taken_o    (br_taken)
  );

  always_comb begin
    unique case (word.mode)
      SEQ_NEXT:     state_d = word.nxt;
      SEQ_BASE:     state_d = ST_BASE;
      SEQ_DISPATCH: state_d = op_entry;
      SEQ_BRANCH:   state_d = br_taken ? word.nxt : ST_BASE;
      default:      state_d = ST_BASE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_BASE;
      opcode_q <= '0;
    end else begin
      state_q <= state_d;
      if (in_base) opcode_q <= mem_data_i;
    end
  end

  assign ctrl_o  = word.sel_op ? op_ctrl : word.ctrl;
  assign state_o = state_q;

  assert_opcode_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_BASE) |=> $stable(opcode_q));

  assert_dispatch_leaves_base_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_BASE) |=> (state_q != ST_BASE));

  assert_nop_one_cycle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_NOP) |=> (state_q == ST_BASE));

  assert_branch_exit_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_BRTEST) |=> (state_q == ST_BASE || state_q == ST_BRTAKE));

  assert_taken_path_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_BRTAKE) |=> (state_q == ST_BRDONE));

  assert_state_range_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(state_q) < NUM_STATES);
endmodule

// File: tb/useq_top_tb.sv
module useq_top_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [7:0]  mem_data_i = 8'h00;
  logic [3:0]  flags_i = 4'h0;
  logic [15:0] ctrl_o;
  logic [6:0]  state_o;

  int checks = 0;
  int failures = 0;
  int exp_state = 0;
  int prev_state = 0;
  int exp_op = 0;
  int last_fetch = 0;

  useq_top u_dut (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .mem_data_i (mem_data_i),
    .flags_i    (flags_i),
    .ctrl_o     (ctrl_o),
    .state_o    (state_o)
  );

  always #4 clk_i = ~clk_i;

  function automatic int entry_of(input int op);
    if (op >= 16 && op <= 23) return 2;
    if (op > 150) return 1;
    return 5 + 4 * (op % 28) + ((op / 28) % 4);
  endfunction

  function automatic int ctrl_of(input int s, input int op);
    bit pass;
    pass = (s == 3) || (s == 4) || (s >= 5 && ((s - 5) % 2) == 1);
    if (pass) return ((op & 255) << 8) | ((op ^ 'h5A) & 255);
    return ((s & 127) << 9) | (1 << 7) | ((~s) & 127);
  endfunction

  // reference model, advanced on every edge
  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      exp_state = 0; prev_state = 0; exp_op = 0;
    end else begin
      prev_state = exp_state;
      case (exp_state)
        0: begin exp_op = int'(mem_data_i); exp_state = entry_of(exp_op); end
        1: exp_state = 0;
        2: exp_state = (((int'(flags_i) >> (exp_op & 3)) & 1) == ((exp_op >> 2) & 1)) ? 3 : 0;
        3: exp_state = 4;
        4: exp_state = 0;
        default:
          if (((exp_state - 5) % 4) == 3 || exp_state == 117) exp_state = 0;
          else exp_state = exp_state + 1;
      endcase
    end
  end

  function automatic string tag_now();
    if (prev_state == 0) return "R2";
    if (prev_state == 2) return "R5";
    if (exp_state == 1 || prev_state == 1) return "R7";
    if (exp_state >= 5 || prev_state >= 5) return "R6";
    return "R4";
  endfunction

  task automatic check(input string tag, input int act, input int expv);
    checks++;
    if (act != expv) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  task automatic compare();
    check(tag_now(), int'(state_o), exp_state);
    check("R4", int'(ctrl_o), ctrl_of(exp_state, exp_op));
    check("R8", int'(state_o <= 7'd117), 1);
  endtask

  task automatic step(input logic [7:0] d, input logic [3:0] f);
    @(negedge clk_i);
    compare();
    mem_data_i = d;
    flags_i = f;
  endtask

  // present op until it is fetched, then let the instruction run with garbage on the bus
  task automatic run_op(input logic [7:0] op, input logic [3:0] f);
    do step(op, f); while (exp_state != 0);
    last_fetch = int'(op);
    step(8'hEE, f);
    while (exp_state != 0) begin
      if (ctrl_of(exp_state, 0) != ctrl_of(exp_state, 1))
        check("R3", int'(ctrl_o[15:8]), last_fetch);
      step(8'hEE ^ 8'(exp_state), f);
    end
  endtask

  initial begin
    repeat (3) begin
      @(negedge clk_i);
      check("R1", int'(state_o), 0);
      check("R1", int'(ctrl_o), 'h00FF);
      mem_data_i = 8'h33;
    end
    rst_ni = 1'b1;
    // undefined opcodes: one no-op cycle
    run_op(8'd151, 4'h0);
    run_op(8'd255, 4'hF);
    run_op(8'd200, 4'h5);
    // boundary valid opcodes
    run_op(8'd0, 4'h0);
    run_op(8'd27, 4'h0);
    run_op(8'd150, 4'h0);
    run_op(8'd139, 4'h0);
    // every branch opcode against every flag pattern
    for (int b = 16; b < 24; b++)
      for (int fl = 0; fl < 16; fl++)
        run_op(8'(b), 4'(fl));
    // full opcode sweep
    for (int op = 0; op < 256; op++)
      run_op(8'(op), 4'(op * 7));
    // free-running bus noise
    for (int i = 0; i < 3000; i++)
      step(8'((i * 37 + 11) & 255), 4'((i * 5) & 15));
    // asynchronous reset mid-instruction
    run_op(8'd5, 4'h0);
    do step(8'd113, 4'h0); while (exp_state != 0);
    step(8'h00, 4'h0);
    step(8'h00, 4'h0);
    rst_ni = 1'b0;
    #1;
    check("R1", int'(state_o), 0);
    check("R1", int'(ctrl_o), 'h00FF);
    @(negedge clk_i);
    rst_ni = 1'b1;
    run_op(8'd151, 4'h0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(8 * 150000);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule